// File: doc/BRIEF.md
# Serial Channel Control Register File

This block holds the control and status registers of one channel of a serial communications controller. Software writes sixteen byte-wide control registers through a simple write port and reads five status registers, or an image of the control registers, through a combinational read port. Most control registers are plain storage. Three of them have side effects:

- Control register 3 manages receiver enable and hunt mode.
- Control register 14 carries a command field that drives the state of the clock-recovery loop (the DPLL) and the enable of the baud-rate generator.
- Control register 7 is redirected to a shadow copy while an enhancement bit in control register 15 is set.

Two reset requests act on the registers synchronously. A hardware reset and a channel reset each combine AND and OR masks with the current contents, and the masks differ between the two kinds. An active-low asynchronous reset loads the values a hardware reset would produce from all-zero contents.

The clock-recovery datapath, the rate generator counter, the shifters and the FIFOs sit outside this block. They see its DPLL state and generator enable as outputs. They report missing clocks and received bytes to it through strobes.

Top module: `scc_chan_regs`

## Requirements
- R1: After `rst_n` is released, the control images read 0x00 everywhere except register 4 = 0x04, register 9 = 0xC0, register 11 = 0x08, register 14 = 0x20 and register 15 = 0xF8. Status register 0 = 0x44, status register 1 = 0x07, status registers 3, 8 and 10 = 0x00, and all four DPLL/generator outputs are 0.
- R2: A write to control registers 0, 1, 2, 4, 5, 6, 8, 9, 10, 11, 12, 13 or 15 stores the byte as written, and the image at that address returns it.
- R3: In a write to register 3, bit 0 (receive enable) and bits 7:5 and 3:1 take the written value. Bit 4 (hunt) becomes 1 if the written bit 4 differs from the stored one, or if the stored bit 0 is 1 and the written bit 0 is 0. Either event also sets status register 0 bit 4. Otherwise bit 4 keeps its value.
- R4: While register 15 bit 0 is 1, a write to address 7 goes to a shadow register and register 7 keeps its value. The image at address 7 returns the shadow while that bit is 1, and register 7 otherwise.
- R5: A write to register 14 decodes bits 7:5 as follows:
  - 000: no operation.
  - 001: DPLL on, and status register 10 bits 7:6 cleared.
  - 010: status register 10 bits 7:6 cleared.
  - 011: DPLL off, and the generator selected as source.
  - 100: the generator selected as source.
  - 101: the pin clock selected as source.
  - 110: FM mode.
  - 111: NRZI mode.
- R6: A write to register 14 sets `brg_on` to written bit 0 and stores {000, bits 4:0} in the register 14 image.
- R7: A hardware reset applies the following; registers 2, 6, 7, 8, 12, 13 and the shadow are unchanged:

  | Register | Result |
  |---|---|
  | 0 | 0 |
  | 1 | AND 0x24 |
  | 3 | AND 0xFE |
  | 4 | OR 0x04 |
  | 5 | AND 0x61 |
  | 9 | (AND 0x03) OR 0xC0 |
  | 10 | 0 |
  | 11 | 0x08 |
  | 14 | (AND 0xC0) OR 0x20 |
  | 15 | 0xF8 |
  | status 0 | (AND 0x38) OR 0x44 |
  | status 1 | 0x07 |
  | status 3 | 0 |
  | status 10 | 0 |

- R8: A channel reset applies the same changes as R7 to registers 0, 1, 3, 4, 5, 15 and to status registers 0, 1, 3 and 10. It differs on four registers: register 9 AND 0xDF, register 10 AND 0x60, register 14 (AND 0xC3) OR 0x20, and register 11 unchanged.
- R9: Either reset sets `dpll_on`, `dpll_src_pin`, `dpll_fm` and `brg_on` to 0.
- R10: `miss_one` sets status register 10 bit 6 and `miss_two` sets bit 7. The flags stay set until command 001 or 010 or a reset clears them; a set in the same cycle as a clear wins.
- R11: `rx_load` stores `rx_byte` in status register 8 and sets status register 0 bit 0. `rx_take` clears that bit, and `rx_load` wins when both are high. Resets leave status register 8 unchanged.
- R12: With `rd_img` = 0, `rd_data` returns status registers 0, 1, 3, 8 and 10 at those addresses and 0x00 at every other address. With `rd_img` = 1 it returns the control image.
- R13: `hw_rst` has priority over `ch_rst`, and either reset has priority over a write in the same cycle; that write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| hw_rst | input | 1 | Hardware reset request, one cycle |
| ch_rst | input | 1 | Channel reset request, one cycle |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Control register address |
| wr_data | input | 8 | Write data |
| rd_img | input | 1 | 1 selects control images, 0 selects status registers |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| rx_load | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_take | input | 1 | Received byte consumed |
| miss_one | input | 1 | One missing clock seen by the DPLL |
| miss_two | input | 1 | Two missing clocks seen by the DPLL |
| dpll_on | output | 1 | DPLL active |
| dpll_src_pin | output | 1 | DPLL source: 1 = pin clock, 0 = generator |
| dpll_fm | output | 1 | DPLL mode: 1 = FM, 0 = NRZI |
| brg_on | output | 1 | Baud-rate generator enabled |

## Verification
The in-line assertions check the following on every cycle:
- A hunt event in register 3 always leaves the sync/hunt flag set.
- A shadowed register 7 write leaves register 7 untouched.
- Command 001 always turns the DPLL on.
- A clear command empties the missing-clock flags.
- A consume strobe drops the byte-available flag.
- Either reset idles the DPLL and generator.
- A hardware reset lands the fixed register values.

Only the bench scenarios show the following:
- The exact masked values that each reset kind leaves in registers that held arbitrary data.
- The image seen through register 7 as the enhancement bit toggles.
- The full sequence of mode and source changes across successive register 14 commands.
- The priority of a hardware reset over a simultaneous channel reset and write.

// File: rtl/scc_chan_pkg.sv
`timescale 1ns/1ps
package scc_chan_pkg;
  localparam int REG_W = 8;
  localparam int IDX_W = 4;
  localparam int N_WR  = 1 << IDX_W;

  typedef enum logic [2:0] {
    CMD_NULL, CMD_SEARCH, CMD_CLR_MISS, CMD_OFF,
    CMD_SRC_GEN, CMD_SRC_PIN, CMD_FM, CMD_NRZI
  } dpll_cmd_e;

  typedef enum logic [1:0] {RST_NONE, RST_CHAN, RST_HARD} rst_kind_e;

  // Control register contents after a reset of kind k, given the old value v.
  function automatic logic [REG_W-1:0] wr_after_reset(
      input rst_kind_e k, input logic [IDX_W-1:0] idx, input logic [REG_W-1:0] v);
    logic hard;
    hard = (k == RST_HARD);
    if (k == RST_NONE) return v;
    case (idx)
      4'd0:    return 8'h00;
      4'd1:    return v & 8'h24;
      4'd3:    return v & 8'hFE;
      4'd4:    return v | 8'h04;
      4'd5:    return v & 8'h61;
      4'd9:    return hard ? ((v & 8'h03) | 8'hC0) : (v & 8'hDF);
      4'd10:   return hard ? 8'h00 : (v & 8'h60);
      4'd11:   return hard ? 8'h08 : v;
      4'd14:   return (v & (hard ? 8'hC0 : 8'hC3)) | 8'h20;
      4'd15:   return 8'hF8;
      default: return v;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] stat0_after_reset(input logic [REG_W-1:0] v);
    return (v & 8'h38) | 8'h44;
  endfunction
endpackage

// File: rtl/scc_hunt_ctl.sv
`timescale 1ns/1ps
module scc_hunt_ctl
  import scc_chan_pkg::*;
(
  input  logic             cur_hunt,
  input  logic             cur_rx,
  input  logic [REG_W-1:0] val,
  output logic [REG_W-1:0] nxt,
  output logic             sync_set
);
  logic hunt_flip, rx_drop;

  always_comb begin
    hunt_flip = cur_hunt ^ val[4];
    rx_drop   = cur_rx & ~val[0];
    sync_set  = hunt_flip | rx_drop;
    nxt       = {val[7:5], cur_hunt | sync_set, val[3:0]};
  end
endmodule

// File: rtl/scc_dpll_cmd.sv
`timescale 1ns/1ps
module scc_dpll_cmd
  import scc_chan_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rst_any,
  input  logic      cmd_valid,
  input  dpll_cmd_e cmd,
  input  logic      gen_bit,
  output logic      dpll_on,
  output logic      src_pin,
  output logic      fm_mode,
  output logic      gen_on,
  output logic      miss_clr
);
  assign miss_clr = cmd_valid && (cmd == CMD_SEARCH || cmd == CMD_CLR_MISS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dpll_on <= 1'b0; src_pin <= 1'b0; fm_mode <= 1'b0; gen_on <= 1'b0;
    end else if (rst_any) begin
      dpll_on <= 1'b0; src_pin <= 1'b0; fm_mode <= 1'b0; gen_on <= 1'b0;
    end else if (cmd_valid) begin
      gen_on <= gen_bit;
      case (cmd)
        CMD_SEARCH:  dpll_on <= 1'b1;
        CMD_OFF:     begin dpll_on <= 1'b0; src_pin <= 1'b0; end
        CMD_SRC_GEN: src_pin <= 1'b0;
        CMD_SRC_PIN: src_pin <= 1'b1;
        CMD_FM:      fm_mode <= 1'b1;
        CMD_NRZI:    fm_mode <= 1'b0;
        default:     ;
      endcase
    end
  end

  assert_search_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == CMD_SEARCH && !rst_any) |=> dpll_on);
  assert_off_gen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd == CMD_OFF && !rst_any) |=> (!dpll_on && !src_pin));
  assert_reset_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_any |=> (!dpll_on && !src_pin && !fm_mode && !gen_on));
endmodule

// File: rtl/scc_chan_regs.sv
`timescale 1ns/1ps
module scc_chan_regs
  import scc_chan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_rst,
  input  logic             ch_rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_img,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [REG_W-1:0] rd_data,
  input  logic             rx_load,
  input  logic [REG_W-1:0] rx_byte,
  input  logic             rx_take,
  input  logic             miss_one,
  input  logic             miss_two,
  output logic             dpll_on,
  output logic             dpll_src_pin,
  output logic             dpll_fm,
  output logic             brg_on
);
  localparam logic [IDX_W-1:0] A_HUNT = IDX_W'(3);
  localparam logic [IDX_W-1:0] A_SHAD = IDX_W'(7);
  localparam logic [IDX_W-1:0] A_CMD  = IDX_W'(14);
  localparam logic [IDX_W-1:0] A_ENH  = IDX_W'(15);

  logic [REG_W-1:0] wreg [N_WR];
  logic [REG_W-1:0] shadow7;
  logic [REG_W-1:0] stat0, stat1, stat3, stat8, stat10;

  rst_kind_e        rkind;
  logic             rst_any, wr_fire, enh_on;
  logic [REG_W-1:0] hunt_nxt;
  logic             hunt_sync, sync_evt, cmd_valid, miss_clr;

  assign rkind     = hw_rst ? RST_HARD : (ch_rst ? RST_CHAN : RST_NONE);
  assign rst_any   = hw_rst | ch_rst;
  assign wr_fire   = wr_en & ~rst_any;
  assign enh_on    = wreg[A_ENH][0];
  assign sync_evt  = wr_fire && (wr_addr == A_HUNT) && hunt_sync;
  assign cmd_valid = wr_fire && (wr_addr == A_CMD);

  scc_hunt_ctl u_hunt (
    .cur_hunt (wreg[A_HUNT][4]),
    .cur_rx   (wreg[A_HUNT][0]),
    .val      (wr_data),
    .nxt      (hunt_nxt),
    .sync_set (hunt_sync)
  );

  scc_dpll_cmd u_dpll (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_any   (rst_any),
    .cmd_valid (cmd_valid),
    .cmd       (dpll_cmd_e'(wr_data[7:5])),
    .gen_bit   (wr_data[0]),
    .dpll_on   (dpll_on),
    .src_pin   (dpll_src_pin),
    .fm_mode   (dpll_fm),
    .gen_on    (brg_on),
    .miss_clr  (miss_clr)
  );

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_WR; i++) wreg[i] <= wr_after_reset(RST_HARD, IDX_W'(i), '0);
      shadow7 <= '0;
    end else if (rst_any) begin
      for (int i = 0; i < N_WR; i++) wreg[i] <= wr_after_reset(rkind, IDX_W'(i), wreg[i]);
    end else if (wr_en) begin
      case (wr_addr)
        A_HUNT:  wreg[A_HUNT] <= hunt_nxt;
        A_SHAD:  if (enh_on) shadow7 <= wr_data; else wreg[A_SHAD] <= wr_data;
        A_CMD:   wreg[A_CMD] <= {3'b000, wr_data[4:0]};
        default: wreg[wr_addr] <= wr_data;
      endcase
    end
  end

  // Status registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat0 <= 8'h44; stat1 <= 8'h07; stat3 <= '0; stat10 <= '0;
    end else if (rst_any) begin
      stat0 <= stat0_after_reset(stat0); stat1 <= 8'h07; stat3 <= '0; stat10 <= '0;
    end else begin
      stat0[4] <= stat0[4] | sync_evt;
      if (rx_load)      stat0[0] <= 1'b1;
      else if (rx_take) stat0[0] <= 1'b0;
      stat10[6] <= miss_one | (stat10[6] & ~miss_clr);
      stat10[7] <= miss_two | (stat10[7] & ~miss_clr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat8 <= '0;
    else if (rx_load) stat8 <= rx_byte;
  end

  always_comb begin
    if (rd_img) begin
      rd_data = (rd_addr == A_SHAD && enh_on) ? shadow7 : wreg[rd_addr];
    end else begin
      case (rd_addr)
        4'd0:    rd_data = stat0;
        4'd1:    rd_data = stat1;
        4'd3:    rd_data = stat3;
        4'd8:    rd_data = stat8;
        4'd10:   rd_data = stat10;
        default: rd_data = '0;
      endcase
    end
  end

  assert_hunt_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |=> stat0[4]);
  assert_shadow_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_addr == A_SHAD && enh_on) |=> $stable(wreg[A_SHAD]));
  assert_hw_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rst |=> (wreg[0] == 8'h00 && wreg[11] == 8'h08 && wreg[15] == 8'hF8 && stat3 == 8'h00));
  assert_ch_keep11_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_rst && !hw_rst) |=> $stable(wreg[11]));
  assert_miss_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_clr && !miss_one && !miss_two && !rst_any) |=> (stat10[7:6] == 2'b00));
  assert_take_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_take && !rx_load && !rst_any) |=> !stat0[0]);
endmodule

// File: tb/scc_chan_regs_test.sv
`timescale 1ns/1ps
module scc_chan_regs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hw_rst = 1'b0, ch_rst = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_img = 1'b0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       rx_load = 1'b0, rx_take = 1'b0, miss_one = 1'b0, miss_two = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       dpll_on, dpll_src_pin, dpll_fm, brg_on;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  scc_chan_regs uut (
    .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst), .ch_rst(ch_rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_img(rd_img), .rd_addr(rd_addr), .rd_data(rd_data),
    .rx_load(rx_load), .rx_byte(rx_byte), .rx_take(rx_take),
    .miss_one(miss_one), .miss_two(miss_two),
    .dpll_on(dpll_on), .dpll_src_pin(dpll_src_pin), .dpll_fm(dpll_fm), .brg_on(brg_on)
  );

  // Row: we, waddr, wdata, rd_img, raddr, expected byte, expected {on,src,fm,brg}
  localparam int NV = 19;
  localparam logic [29:0] VEC [NV] = '{
    {1'b1, 4'd2,  8'h5A, 1'b1, 4'd2,  8'h5A, 4'b0000},
    {1'b1, 4'd3,  8'h01, 1'b1, 4'd3,  8'h01, 4'b0000},
    {1'b0, 4'd0,  8'h00, 1'b0, 4'd0,  8'h44, 4'b0000},
    {1'b1, 4'd3,  8'hC0, 1'b1, 4'd3,  8'hD0, 4'b0000},
    {1'b0, 4'd0,  8'h00, 1'b0, 4'd0,  8'h54, 4'b0000},
    {1'b1, 4'd3,  8'h11, 1'b1, 4'd3,  8'h11, 4'b0000},
    {1'b1, 4'd15, 8'h01, 1'b1, 4'd15, 8'h01, 4'b0000},
    {1'b1, 4'd7,  8'h3C, 1'b1, 4'd7,  8'h3C, 4'b0000},
    {1'b1, 4'd15, 8'h00, 1'b1, 4'd7,  8'h00, 4'b0000},
    {1'b1, 4'd7,  8'h99, 1'b1, 4'd7,  8'h99, 4'b0000},
    {1'b1, 4'd14, 8'h01, 1'b1, 4'd14, 8'h01, 4'b0001},
    {1'b1, 4'd14, 8'h20, 1'b1, 4'd14, 8'h00, 4'b1000},
    {1'b1, 4'd14, 8'hA1, 1'b1, 4'd14, 8'h01, 4'b1101},
    {1'b1, 4'd14, 8'hC0, 1'b1, 4'd14, 8'h00, 4'b1110},
    {1'b1, 4'd14, 8'h60, 1'b1, 4'd14, 8'h00, 4'b0010},
    {1'b1, 4'd14, 8'hE0, 1'b1, 4'd14, 8'h00, 4'b0000},
    {1'b1, 4'd14, 8'hA0, 1'b1, 4'd14, 8'h00, 4'b0100},
    {1'b1, 4'd14, 8'h80, 1'b1, 4'd14, 8'h00, 4'b0000},
    {1'b0, 4'd0,  8'h00, 1'b0, 4'd2,  8'h00, 4'b0000}
  };

  function automatic string row_tag(input int i);
    if (i == 0) return "R2";
    if (i <= 5) return "R3";
    if (i <= 9) return "R4";
    if (i == 10) return "R6";
    if (i <= 17) return "R5";
    return "R12";
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic img, input logic [3:0] a, output logic [7:0] v);
    rd_img = img; rd_addr = a;
    #0.5;
    v = rd_data;
  endtask

  task automatic img_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    peek(1'b1, a, v);
    chk(tag, v, exp);
  endtask

  task automatic st_chk(input string tag, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    peek(1'b0, a, v);
    chk(tag, v, exp);
  endtask

  task automatic out_chk(input string tag, input logic [3:0] exp);
    chk(tag, {4'h0, dpll_on, dpll_src_pin, dpll_fm, brg_on}, {4'h0, exp});
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rx_pulse(input logic ld, input logic tk, input logic [7:0] b);
    @(negedge clk); rx_load = ld; rx_take = tk; rx_byte = b;
    @(negedge clk); rx_load = 1'b0; rx_take = 1'b0;
  endtask

  task automatic miss_pulse(input logic one, input logic two);
    @(negedge clk); miss_one = one; miss_two = two;
    @(negedge clk); miss_one = 1'b0; miss_two = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: state after power-on reset
    img_chk("R1 wr0", 4'd0, 8'h00);
    img_chk("R1 wr4", 4'd4, 8'h04);
    img_chk("R1 wr9", 4'd9, 8'hC0);
    img_chk("R1 wr11", 4'd11, 8'h08);
    img_chk("R1 wr14", 4'd14, 8'h20);
    img_chk("R1 wr15", 4'd15, 8'hF8);
    img_chk("R1 wr7", 4'd7, 8'h00);
    st_chk("R1 st0", 4'd0, 8'h44);
    st_chk("R1 st1", 4'd1, 8'h07);
    st_chk("R1 st10", 4'd10, 8'h00);
    out_chk("R1 outs", 4'b0000);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [29:0] row;
      row = VEC[i];
      if (row[29]) wr(row[28:25], row[24:17]);
      if (row[16]) img_chk(row_tag(i), row[15:12], row[11:4]);
      else st_chk(row_tag(i), row[15:12], row[11:4]);
      out_chk({row_tag(i), " outs"}, row[3:0]);
    end

    // R12: image and status differ at address 0
    img_chk("R12 img0", 4'd0, 8'h00);

    // R11: received byte handling
    rx_pulse(1'b1, 1'b0, 8'hA7);
    st_chk("R11 st8", 4'd8, 8'hA7);
    st_chk("R11 avail", 4'd0, 8'h55);
    rx_pulse(1'b0, 1'b1, 8'h00);
    st_chk("R11 take", 4'd0, 8'h54);
    rx_pulse(1'b1, 1'b1, 8'h3E);
    st_chk("R11 load wins", 4'd0, 8'h55);
    rx_pulse(1'b0, 1'b1, 8'h00);
    st_chk("R11 take2", 4'd0, 8'h54);

    // R10: missing-clock flags
    miss_pulse(1'b1, 1'b0);
    st_chk("R10 one", 4'd10, 8'h40);
    miss_pulse(1'b0, 1'b1);
    st_chk("R10 two", 4'd10, 8'hC0);
    wr(4'd14, 8'h40);
    st_chk("R10 clr cmd", 4'd10, 8'h00);
    out_chk("R10 clr outs", 4'b0000);
    miss_pulse(1'b1, 1'b1);
    wr(4'd14, 8'h20);
    st_chk("R10 search clr", 4'd10, 8'h00);
    out_chk("R5 search on", 4'b1000);

    // R8: channel reset masks
    wr(4'd0, 8'hFF); wr(4'd1, 8'hFF); wr(4'd4, 8'h00); wr(4'd5, 8'hFF);
    wr(4'd9, 8'hFF); wr(4'd10, 8'hFF); wr(4'd11, 8'hFF); wr(4'd14, 8'h1F);
    out_chk("R6 gen on", 4'b1001);
    rx_pulse(1'b1, 1'b0, 8'h11);
    miss_pulse(1'b1, 1'b1);
    @(negedge clk); ch_rst = 1'b1;
    @(negedge clk); ch_rst = 1'b0;
    img_chk("R8 wr0", 4'd0, 8'h00);
    img_chk("R8 wr1", 4'd1, 8'h24);
    img_chk("R8 wr2", 4'd2, 8'h5A);
    img_chk("R8 wr3", 4'd3, 8'h10);
    img_chk("R8 wr4", 4'd4, 8'h04);
    img_chk("R8 wr5", 4'd5, 8'h61);
    img_chk("R8 wr9", 4'd9, 8'hDF);
    img_chk("R8 wr10", 4'd10, 8'h60);
    img_chk("R8 wr11", 4'd11, 8'hFF);
    img_chk("R8 wr14", 4'd14, 8'h23);
    img_chk("R8 wr15", 4'd15, 8'hF8);
    st_chk("R8 st0", 4'd0, 8'h54);
    st_chk("R8 st1", 4'd1, 8'h07);
    st_chk("R8 st10", 4'd10, 8'h00);
    st_chk("R11 st8 kept", 4'd8, 8'h11);
    out_chk("R9 ch outs", 4'b0000);

    // R7 / R13: hardware reset, with channel reset and a write in the same cycle
    wr(4'd9, 8'hFF); wr(4'd10, 8'hFF); wr(4'd14, 8'h1F);
    @(negedge clk);
    hw_rst = 1'b1; ch_rst = 1'b1; wr_en = 1'b1; wr_addr = 4'd10; wr_data = 8'h33;
    @(negedge clk);
    hw_rst = 1'b0; ch_rst = 1'b0; wr_en = 1'b0;
    img_chk("R7 wr1", 4'd1, 8'h24);
    img_chk("R7 wr7", 4'd7, 8'h99);
    img_chk("R7 wr9", 4'd9, 8'hC3);
    img_chk("R13 wr10", 4'd10, 8'h00);
    img_chk("R13 wr11", 4'd11, 8'h08);
    img_chk("R7 wr14", 4'd14, 8'h20);
    img_chk("R7 wr15", 4'd15, 8'hF8);
    out_chk("R9 hw outs", 4'b0000);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule